// File: doc/BRIEF.md
# Multiplexed BCD Digit Scanner

This block is the digital back end of a three-and-a-half digit dual-slope converter. At the end of each conversion, the counter logic offers a result: a half digit, three BCD digits, a polarity bit and an above-full-scale flag. The block keeps the last accepted result in output latches. It then scans that result onto one shared 4-bit bus, one digit at a time. Each digit is marked by its own active-high select line.

A result is accepted only if a display-update request arrives in time. The request is a rising edge on an asynchronous input, and it must be seen before the ramp-down phase of the same cycle. Without such a request, the previous result stays on display.

The end of a conversion is marked by a one-clock strobe from the sequencer. For each strobe, the block produces a half-period end-of-conversion pulse. It also restarts the scan so that the half digit comes up next. A separate output, active low, shows the overrange condition.

Top module: `bcd_scan_mux`

## Requirements
- R1: At most one of the four select outputs is high at any time. While no select is high, the bus reads 4'h0.
- R2: Each digit slot lasts 20 clocks: 2 blanking clocks with all selects low, then 18 clocks with that slot's select high. A full pass through the four slots takes 80 clocks.
- R3: The slots run in the order half digit (`dsel_o[3]`), then `dig2`, then `dig1`, then `dig0` (`dsel_o[0]`), and then wrap back to the half digit.
- R4: Suppose `conv_end_i` is sampled high at a clock edge. In the following cycle, `eoc_o` is high during the clock-low half only, and the scan is in the blanking clock just before the half-digit slot. In the cycle after that, `dsel_o` is 4'b1000.
- R5: A result is loaded at a `conv_end_i` edge only if `disp_upd_i` has risen since the previous such edge while `ramp_down_i` was low. A rise counts once it has passed a two-flop synchronizer, so it must come at least 3 clocks before the strobe. Without such a rise, the displayed result is unchanged.
- R6: A rise on `disp_upd_i` that is detected while `ramp_down_i` is high is ignored and does not cause a load.
- R7: During the half-digit slot, the bus carries {0, sign, 0, half}, where sign 1 means positive. During the other slots, it carries the BCD value of that digit.
- R8: `over_n_o` is high normally and low while the latched result has its overrange flag set.
- R9: Reset clears the latches, so the bus shows zeros and `over_n_o` is 1. It also drives all selects low and `eoc_o` low, and starts the scan at the first blanking clock of the half-digit slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| conv_end_i | input | 1 | One-clock end-of-conversion strobe from the sequencer |
| ramp_down_i | input | 1 | High while the converter is in ramp-down |
| disp_upd_i | input | 1 | Asynchronous display-update request, rising edge |
| half_i | input | 1 | Half-digit value of the new result |
| sign_i | input | 1 | Polarity of the new result, 1 for positive |
| over_i | input | 1 | New result is above full scale |
| dig2_i | input | 4 | Most significant full BCD digit |
| dig1_i | input | 4 | Middle BCD digit |
| dig0_i | input | 4 | Least significant BCD digit |
| bcd_o | output | 4 | Shared multiplexed BCD bus |
| dsel_o | output | 4 | Digit selects, active high, bit 3 is the half digit |
| eoc_o | output | 1 | End-of-conversion pulse, half a clock wide |
| over_n_o | output | 1 | Overrange, active low |

## Verification
A display-update rise takes three clock edges to become a pending load: two synchronizer edges and one capture edge. The bench therefore holds `disp_upd_i` for four clocks before it issues the strobe. The new result and the half-digit select appear one clock after the `eoc_o` cycle. `eoc_o` itself is checked in the clock-low half right after the strobe's edge. From there, the bench steps one clock at a time through 80 cycles, sampling just after each falling edge. At each step it compares the selects and the bus against a slot and position that it computes itself from the number of cycles since the strobe.

// File: rtl/bcd_scan_pkg.sv
package bcd_scan_pkg;
  localparam int BCD_W = 4;

  typedef struct packed {
    logic             half;
    logic             sign;
    logic             over;
    logic [BCD_W-1:0] d2;
    logic [BCD_W-1:0] d1;
    logic [BCD_W-1:0] d0;
  } result_t;
endpackage

// File: rtl/du_edge_sync.sv
module du_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-1:0], async_i};
  end

  assign rise_o = sr_q[STAGES-1] & ~sr_q[STAGES];
endmodule

// File: rtl/result_latch.sv
module result_latch
  import bcd_scan_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  result_t res_i,
  input  logic    rise_i,
  input  logic    ramp_i,
  input  logic    conv_end_i,
  output result_t res_o,
  output logic    load_o
);
  logic    pend_q;
  logic    qual;
  result_t res_q;

  assign qual   = rise_i & ~ramp_i;
  assign load_o = conv_end_i & (pend_q | qual);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pend_q <= 1'b0;
    else if (conv_end_i) pend_q <= 1'b0;
    else if (qual)       pend_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     res_q <= '0;
    else if (load_o) res_q <= res_i;
  end

  assign res_o = res_q;

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_o |=> $stable(res_q));

  p_ignore_ramp_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_q && ramp_i && !conv_end_i) |=> !pend_q);

  p_pend_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_end_i |=> !pend_q);
endmodule

// File: rtl/scan_seq.sv
module scan_seq #(
  parameter int NUM_SEL    = 4,
  parameter int SLOT_CLKS  = 20,
  parameter int BLANK_CLKS = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       restart_i,
  output logic [$clog2(NUM_SEL)-1:0] slot_o,
  output logic                       act_o,
  output logic [NUM_SEL-1:0]         dsel_o
);
  localparam int PW = $clog2(SLOT_CLKS);
  localparam int SW = $clog2(NUM_SEL);
  localparam logic [PW-1:0] POS_LAST  = PW'(SLOT_CLKS - 1);
  localparam logic [PW-1:0] POS_BLANK = PW'(BLANK_CLKS);
  localparam logic [PW-1:0] POS_PRE   = PW'(BLANK_CLKS - 1);
  localparam logic [SW-1:0] SLOT_LAST = SW'(NUM_SEL - 1);

  logic [PW-1:0] pos_q;
  logic [SW-1:0] slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      slot_q <= '0;
    end else if (restart_i) begin
      pos_q  <= POS_PRE;
      slot_q <= '0;
    end else if (pos_q == POS_LAST) begin
      pos_q  <= '0;
      slot_q <= (slot_q == SLOT_LAST) ? '0 : slot_q + 1'b1;
    end else begin
      pos_q  <= pos_q + 1'b1;
    end
  end

  assign act_o  = (pos_q >= POS_BLANK);
  assign slot_o = slot_q;

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
    assign dsel_o[NUM_SEL-1-g] = act_o && (slot_q == SW'(g));
  end

  p_onehot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dsel_o));

  p_restart_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (pos_q == POS_PRE) && (slot_q == '0));

  p_slot_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_q == POS_LAST && !restart_i) |=> (pos_q == '0) && !act_o);

  p_order_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_q == POS_LAST && slot_q != SLOT_LAST && !restart_i)
      |=> slot_q == $past(slot_q) + 1'b1);
endmodule

// File: rtl/bcd_scan_mux.sv
module bcd_scan_mux
  import bcd_scan_pkg::*;
#(
  parameter int SLOT_CLKS   = 20,
  parameter int BLANK_CLKS  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             conv_end_i,
  input  logic             ramp_down_i,
  input  logic             disp_upd_i,
  input  logic             half_i,
  input  logic             sign_i,
  input  logic             over_i,
  input  logic [BCD_W-1:0] dig2_i,
  input  logic [BCD_W-1:0] dig1_i,
  input  logic [BCD_W-1:0] dig0_i,
  output logic [BCD_W-1:0] bcd_o,
  output logic [3:0]       dsel_o,
  output logic             eoc_o,
  output logic             over_n_o
);
  localparam int NUM_SEL = 4;
  localparam int SW      = $clog2(NUM_SEL);

  logic          rise;
  logic          load;
  logic          eoc_q;
  logic          act;
  logic [SW-1:0] slot;
  result_t       res_in, res_q;

  assign res_in = '{half: half_i, sign: sign_i, over: over_i,
                    d2: dig2_i, d1: dig1_i, d0: dig0_i};

  du_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(disp_upd_i),
    .rise_o (rise)
  );

  result_latch u_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .res_i     (res_in),
    .rise_i    (rise),
    .ramp_i    (ramp_down_i),
    .conv_end_i(conv_end_i),
    .res_o     (res_q),
    .load_o    (load)
  );

  scan_seq #(
    .NUM_SEL   (NUM_SEL),
    .SLOT_CLKS (SLOT_CLKS),
    .BLANK_CLKS(BLANK_CLKS)
  ) u_scan (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(conv_end_i),
    .slot_o   (slot),
    .act_o    (act),
    .dsel_o   (dsel_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) eoc_q <= 1'b0;
    else         eoc_q <= conv_end_i;
  end

  // half-period pulse: registered strobe gated to the clock-low phase
  assign eoc_o = eoc_q & ~clk_i;

  always_comb begin
    bcd_o = '0;
    if (act) begin
      unique case (slot)
        2'd0:    bcd_o = {1'b0, res_q.sign, 1'b0, res_q.half};
        2'd1:    bcd_o = res_q.d2;
        2'd2:    bcd_o = res_q.d1;
        default: bcd_o = res_q.d0;
      endcase
    end
  end

  assign over_n_o = ~res_q.over;

  p_blank_bus_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dsel_o == 4'b0000) |-> (bcd_o == '0));

  p_eoc_sel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoc_q && !conv_end_i) |=> (dsel_o == 4'b1000));

  p_over_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> (over_n_o != $past(over_i)));
endmodule

// File: tb/tb_bcd_scan_mux.sv
module tb_bcd_scan_mux;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       conv_end_i = 1'b0, ramp_down_i = 1'b0, disp_upd_i = 1'b0;
  logic       half_i = 1'b0, sign_i = 1'b0, over_i = 1'b0;
  logic [3:0] dig2_i = '0, dig1_i = '0, dig0_i = '0;
  logic [3:0] bcd_o, dsel_o;
  logic       eoc_o, over_n_o;

  int n_chk = 0, n_bad = 0;
  logic done = 1'b0;

  // exp_* hold the result the display should show
  logic       e_half = 0, e_sign = 0, e_over = 0;
  logic [3:0] e_d2 = 0, e_d1 = 0, e_d0 = 0;

  always #5 clk_i = ~clk_i;

  bcd_scan_mux dut (.*);

  // [16]half [15]sign [14]over [13:10]d2 [9:6]d1 [5:2]d0 [1:0]mode
  // mode 0: no update, 1: update with ramp low, 2: update during ramp
  localparam logic [16:0] VEC [6] = '{
    {1'b1, 1'b1, 1'b0, 4'd9, 4'd9, 4'd9, 2'd1},
    {1'b0, 1'b0, 1'b0, 4'd1, 4'd2, 4'd3, 2'd1},
    {1'b1, 1'b0, 1'b1, 4'd0, 4'd0, 4'd0, 2'd1},
    {1'b0, 1'b1, 1'b0, 4'd5, 4'd6, 4'd7, 2'd0},
    {1'b0, 1'b1, 1'b0, 4'd4, 4'd4, 4'd4, 2'd2},
    {1'b0, 1'b1, 1'b0, 4'd8, 4'd0, 4'd7, 2'd1}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
    #1;
  endtask

  task automatic exp_out(input int t, output logic [3:0] sel, output logic [3:0] bus);
    int g, slot, pos;
    g    = (1 + t) % 80;
    slot = g / 20;
    pos  = g % 20;
    sel  = '0;
    bus  = '0;
    if (pos >= 2) begin
      sel = 4'b1000 >> slot;
      case (slot)
        0: bus = {1'b0, e_sign, 1'b0, e_half};
        1: bus = e_d2;
        2: bus = e_d1;
        default: bus = e_d0;
      endcase
    end
  endtask

  task automatic strobe_and_scan(input string tag);
    logic [3:0] es, eb;
    conv_end_i = 1'b1;
    step();
    conv_end_i = 1'b0;
    chk({tag, " R4 eoc high in low phase"}, eoc_o, 1);
    chk({tag, " R4 blank at eoc"}, dsel_o, 0);
    for (int t = 1; t <= 80; t++) begin
      step();
      if (t == 1) chk({tag, " R4 eoc single"}, eoc_o, 0);
      exp_out(t, es, eb);
      chk({tag, " R1 R2 R3 select"}, dsel_o, es);
      chk({tag, " R5 R7 bus"}, bcd_o, eb);
    end
    chk({tag, " R8 overrange"}, over_n_o, !e_over);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    step();
    step();
    rst_ni = 1'b1;
    // R9 reset state, scan begins at first blanking clock
    chk("R9 sel after reset", dsel_o, 0);
    chk("R9 bus after reset", bcd_o, 0);
    chk("R9 over_n after reset", over_n_o, 1);
    chk("R9 eoc after reset", eoc_o, 0);
    step();
    chk("R9 R2 second blank", dsel_o, 0);
    step();
    chk("R9 R3 half first", dsel_o, 4'b1000);
    chk("R9 R7 cleared bus", bcd_o, 0);

    for (int i = 0; i < 6; i++) begin
      logic [16:0] v;
      v = VEC[i];
      {half_i, sign_i, over_i, dig2_i, dig1_i, dig0_i} = v[16:2];
      if (v[1:0] == 2'd1) begin
        disp_upd_i = 1'b1;
        repeat (4) step();
        disp_upd_i = 1'b0;
        {e_half, e_sign, e_over, e_d2, e_d1, e_d0} = v[16:2];
      end else if (v[1:0] == 2'd2) begin
        ramp_down_i = 1'b1;
        step();
        disp_upd_i = 1'b1;
        repeat (4) step();
        disp_upd_i = 1'b0;
        repeat (2) step();
        ramp_down_i = 1'b0;
        // R6: the ignored edge leaves the display unchanged
      end else begin
        repeat (3) step();
      end
      step();
      strobe_and_scan($sformatf("vec%0d", i));
    end

    // R5: request raised too late (one clock before strobe) is not loaded yet
    {half_i, sign_i, over_i, dig2_i, dig1_i, dig0_i} = {1'b1, 1'b0, 1'b1, 4'd3, 4'd3, 4'd3};
    disp_upd_i = 1'b1;
    step();
    strobe_and_scan("late R5");
    disp_upd_i = 1'b0;
    // the pending rise lands after the strobe and loads at the next one
    {e_half, e_sign, e_over, e_d2, e_d1, e_d0} = {1'b1, 1'b0, 1'b1, 4'd3, 4'd3, 4'd3};
    strobe_and_scan("next R5");

    // R9: reset in mid-scan clears latched result
    repeat (7) step();
    rst_ni = 1'b0;
    step();
    rst_ni = 1'b1;
    chk("R9 mid reset over_n", over_n_o, 1);
    chk("R9 mid reset sel", dsel_o, 0);
    step();
    step();
    chk("R9 mid reset half sel", dsel_o, 4'b1000);
    chk("R9 mid reset bus", bcd_o, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule